// File: doc/BRIEF.md
# Double-Buffered Clock-Synchronous Serial Byte Path

This block moves bytes between a processor-side register interface and a clock-synchronous serial line. Both directions share a single shift register. A holding register sits on the transmit side and a receive buffer register sits on the receive side. The processor writes a byte into the holding register through a valid/ready handshake. As soon as the shift register is free, that byte moves into it and starts shifting out. If a further byte is already waiting in the holding register when the current byte completes, it is loaded on the same cycle, so transfers run back to back without an idle serial clock period.

Serial timing comes from a single-cycle enable input, `sck_tick`. While a byte is in flight, each tick toggles the serial clock output. On a rising phase the input line is sampled. On the next falling phase the shift register advances and the next output bit appears. Each byte received in the shift register is handed to the receive buffer and offered on a valid/ready read port.

If a byte completes while the previous one is still unread, an overrun is flagged and the buffer keeps the older byte. The `lsb_first` mode input selects the bit order. In LSB-first mode the holding register stores the byte in reversed bit order, and its readback shows that reversed byte. The receive side reverses the byte back on delivery.

Top module: `sser_dbuf_path`

## Requirements
- R1: After reset, `tx_view` and `rx_data` both read 0xFF, `tx_ready` is 1, and `rx_valid`, `ovr_flag` and `sck` are 0.
- R2: A byte is accepted on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is low on the next cycle and stays low until the byte moves into the shift register. That move happens one cycle later if the shift register is idle, otherwise at the end of the current byte. `tx_valid` with `tx_ready` low has no effect.
- R3: If a byte is waiting when the current byte finishes, it starts with no gap, so successive byte deliveries are exactly 2*W ticks apart.
- R4: The serial clock output changes only on the cycle after a `sck_tick`. While a byte is in flight, ticks alternately raise `sck` (which samples `sdi`) and lower it (which advances `sdo`). When a byte is loaded, `sdo` shows bit W-1 in MSB-first mode (`lsb_first`=0) and bit 0 in LSB-first mode.
- R5: `tx_view` returns the byte as written when `lsb_first` was 0 at the write, and the bit-reversed byte (bit i moves to bit W-1-i) when it was 1.
- R6: After the W-th falling phase, the byte built from the sampled `sdi` bits appears on `rx_data` with `rx_valid` high. The first bit sampled is bit W-1 in MSB-first mode and bit 0 in LSB-first mode. With `sdo` looped back to `sdi`, the written byte is returned.
- R7: `rx_valid` stays high and `rx_data` stays unchanged until a cycle with `rx_ready` high, and `rx_valid` drops after that cycle unless a new byte lands on the same edge.
- R8: A byte that completes while `rx_valid` is high and not being read sets `ovr_flag` and is discarded, so `rx_data` keeps the older byte. While `ovr_flag` is set, every completed byte is discarded. `ovr_flag` stays set until a cycle with `ovr_clr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsb_first | input | 1 | 1 selects LSB-first bit order, 0 selects MSB-first |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register is empty and can take a byte |
| tx_data | input | W | Transmit byte |
| tx_view | output | W | Readback of the holding register |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Reader takes the byte this cycle |
| rx_data | output | W | Receive buffer contents |
| ovr_flag | output | 1 | Sticky overrun indication |
| ovr_clr | input | 1 | Clears the overrun flag |
| sck_tick | input | 1 | Serial clock phase enable, one cycle wide |
| sck | output | 1 | Serial clock output, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default width W=8 and drives `sck_tick` on every fourth clock. This makes the 16-tick spacing between back-to-back deliveries an exact, measurable figure. Looping `sdo` to `sdi` lets every transmitted byte be compared with what returns through the receive buffer in both bit orders. Holding off reads across three transfers reaches the overrun case, including the discard of a byte that arrives while the flag is already set.

// File: rtl/sser_pkg.sv
package sser_pkg;
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } sck_phase_e;
endpackage

// File: rtl/sser_txhold.sv
module sser_txhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_first,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] hold_q,
  output logic         hold_full
);
  logic [W-1:0] wr_rev;

  // Store in shift order: LSB-first bytes are kept reversed.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign wr_rev[i] = wr_data[W-1-i];
  end

  assign wr_ready = ~hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '1;
      hold_full <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      hold_q    <= lsb_first ? wr_rev : wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/sser_shift.sv
module sser_shift
  import sser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold_full,
  input  logic [W-1:0] hold_q,
  output logic         take,
  input  logic         sdi,
  output logic         sdo,
  output logic         sck,
  output logic         done,
  output logic [W-1:0] done_byte
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic          busy;
  sck_phase_e    ph;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic          samp;
  logic          last;
  logic          fall_edge;

  assign last      = (cnt == CW'(W - 1));
  assign fall_edge = busy && tick && (ph == PH_FALL);
  assign done      = fall_edge && last;
  assign done_byte = {sh[W-2:0], samp};
  assign take      = hold_full && (!busy || done);
  assign sdo       = sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= PH_RISE;
      cnt  <= '0;
      sh   <= '0;
      samp <= 1'b0;
      sck  <= 1'b0;
    end else if (!busy) begin
      if (hold_full) begin
        sh   <= hold_q;
        busy <= 1'b1;
        cnt  <= '0;
        ph   <= PH_RISE;
      end
    end else if (tick) begin
      if (ph == PH_RISE) begin
        sck  <= 1'b1;
        samp <= sdi;
        ph   <= PH_FALL;
      end else begin
        sck <= 1'b0;
        ph  <= PH_RISE;
        if (last) begin
          cnt <= '0;
          if (hold_full) begin
            sh <= hold_q;
          end else begin
            busy <= 1'b0;
            sh   <= {sh[W-2:0], samp};
          end
        end else begin
          cnt <= cnt + 1'b1;
          sh  <= {sh[W-2:0], samp};
        end
      end
    end
  end
endmodule

// File: rtl/sser_rxbuf.sv
module sser_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_first,
  input  logic         done,
  input  logic [W-1:0] done_byte,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         ovr,
  input  logic         ovr_clr
);
  logic [W-1:0] byte_rev;
  logic         full_left;
  logic         deliver;
  logic         overrun_hit;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign byte_rev[i] = done_byte[W-1-i];
  end

  assign full_left   = rd_valid && !rd_ready;
  assign deliver     = done && !ovr && !full_left;
  assign overrun_hit = done && !ovr && full_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '1;
      rd_valid <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      rd_valid <= deliver || full_left;
      ovr      <= overrun_hit || (ovr && !ovr_clr);
      if (deliver) rd_data <= lsb_first ? byte_rev : done_byte;
    end
  end
endmodule

// File: rtl/sser_dbuf_path.sv
module sser_dbuf_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_first,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic [W-1:0] tx_view,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         ovr_flag,
  input  logic         ovr_clr,
  input  logic         sck_tick,
  output logic         sck,
  output logic         sdo,
  input  logic         sdi
);
  logic         hold_full;
  logic         take;
  logic         done;
  logic [W-1:0] done_byte;

  sser_txhold #(.W(W)) u_txhold (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first),
    .wr_valid(tx_valid), .wr_ready(tx_ready), .wr_data(tx_data),
    .take(take), .hold_q(tx_view), .hold_full(hold_full)
  );

  sser_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(sck_tick),
    .hold_full(hold_full), .hold_q(tx_view), .take(take),
    .sdi(sdi), .sdo(sdo), .sck(sck),
    .done(done), .done_byte(done_byte)
  );

  sser_rxbuf #(.W(W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first),
    .done(done), .done_byte(done_byte),
    .rd_valid(rx_valid), .rd_ready(rx_ready), .rd_data(rx_data),
    .ovr(ovr_flag), .ovr_clr(ovr_clr)
  );
endmodule

// File: rtl/sser_dbuf_path_chk.sv
module sser_dbuf_path_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic [W-1:0] rx_data,
  input logic         ovr_flag,
  input logic         ovr_clr,
  input logic         sck_tick,
  input logic         sck
);
  p_wr_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_sck_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_tick |=> $stable(sck));

  p_rx_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_rx_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> $stable(rx_data));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

bind sser_dbuf_path sser_dbuf_path_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .sck_tick(sck_tick), .sck(sck)
);

// File: tb/sser_dbuf_path_bench.sv
module sser_dbuf_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lsb_first = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] tx_view;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic [W-1:0] rx_data;
  logic ovr_flag;
  logic ovr_clr = 1'b0;
  logic sck_tick = 1'b0;
  logic sck;
  logic sdo;

  int n_chk = 0;
  int n_fail = 0;
  int n_ticks = 0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sser_dbuf_path #(.W(W)) u_sser_dbuf_path (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_view(tx_view), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
    .sck_tick(sck_tick), .sck(sck), .sdo(sdo), .sdi(sdo)
  );

  // Tick on every fourth clock, counted as it is issued.
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv = 0;
      sck_tick = 1'b0;
    end else begin
      if (sck_tick) n_ticks++;
      tdiv = (tdiv + 1) % 4;
      sck_tick = (tdiv == 0);
    end
  end

  function automatic logic [W-1:0] rev(input logic [W-1:0] b);
    for (int i = 0; i < W; i++) rev[i] = b[W-1-i];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rd(output logic [W-1:0] b, output int ts);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    b  = rx_data;
    ts = n_ticks;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    logic [W-1:0] b;
    int ts0, ts1, ts2;
    logic [W-1:0] c0, c1, c2;
    void'($urandom(32'h5eed1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_view == 8'hFF, "R1", "tx_view", tx_view, 8'hFF);
    check(rx_data == 8'hFF, "R1", "rx_data", rx_data, 8'hFF);
    check(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    check(ovr_flag == 1'b0, "R1", "ovr_flag", ovr_flag, 0);
    check(sck == 1'b0, "R1", "sck", sck, 0);

    // R2/R4/R5/R6 MSB-first directed
    lsb_first = 1'b0;
    wr(8'hA5);
    check(tx_ready == 1'b0, "R2", "tx_ready after write", tx_ready, 0);
    check(tx_view == 8'hA5, "R5", "msb readback", tx_view, 8'hA5);
    @(negedge clk);
    check(tx_ready == 1'b1, "R2", "tx_ready after load", tx_ready, 1);
    check(sdo == 1'b1, "R4", "first bit msb", sdo, 1);
    check(sck == 1'b0, "R4", "sck before rise", sck, 0);
    rd(got, ts0);
    check(got == 8'hA5, "R6", "msb loopback", got, 8'hA5);
    @(negedge clk);
    check(rx_valid == 1'b0, "R7", "rx_valid after read", rx_valid, 0);

    // R4/R5/R6 LSB-first directed
    lsb_first = 1'b1;
    wr(8'h01);
    check(tx_view == 8'h80, "R5", "lsb readback", tx_view, 8'h80);
    @(negedge clk);
    check(sdo == 1'b1, "R4", "first bit lsb", sdo, 1);
    rd(got, ts0);
    check(got == 8'h01, "R6", "lsb loopback", got, 8'h01);
    wr(8'h3C);
    check(tx_view == 8'h3C, "R5", "lsb readback sym", tx_view, 8'h3C);
    rd(got, ts0);
    check(got == 8'h3C, "R6", "lsb loopback 3C", got, 8'h3C);

    // R3 continuous transfer
    lsb_first = 1'b0;
    fork
      begin
        wr(8'h11); wr(8'h22); wr(8'h33);
      end
      begin
        rd(c0, ts0); rd(c1, ts1); rd(c2, ts2);
      end
    join
    check(c0 == 8'h11, "R3", "stream byte0", c0, 8'h11);
    check(c1 == 8'h22, "R3", "stream byte1", c1, 8'h22);
    check(c2 == 8'h33, "R3", "stream byte2", c2, 8'h33);
    check(ts1 - ts0 == 2*W, "R3", "gap 0-1 ticks", ts1 - ts0, 2*W);
    check(ts2 - ts1 == 2*W, "R3", "gap 1-2 ticks", ts2 - ts1, 2*W);

    // R8 overrun, older byte kept, later byte discarded
    wr(8'hC3); wr(8'h5A); wr(8'h96);
    repeat (300) @(negedge clk);
    check(ovr_flag == 1'b1, "R8", "ovr set", ovr_flag, 1);
    check(rx_valid == 1'b1, "R7", "rx_valid held", rx_valid, 1);
    check(rx_data == 8'hC3, "R8", "old byte kept", rx_data, 8'hC3);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check(ovr_flag == 1'b0, "R8", "ovr cleared", ovr_flag, 0);
    rd(got, ts0);
    check(got == 8'hC3, "R8", "read old byte", got, 8'hC3);
    @(negedge clk);
    check(rx_valid == 1'b0, "R8", "discarded bytes absent", rx_valid, 0);
    wr(8'h7E);
    rd(got, ts0);
    check(got == 8'h7E, "R8", "delivery after clear", got, 8'h7E);

    // Random mix of bytes and orders
    for (int k = 0; k < 24; k++) begin
      lsb_first = 1'($urandom_range(0, 1));
      b = W'($urandom);
      wr(b);
      check(tx_view == (lsb_first ? rev(b) : b), "R5", "random readback",
            tx_view, lsb_first ? rev(b) : b);
      rd(got, ts0);
      check(got == b, "R6", "random loopback", got, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule